// File: doc/BRIEF.md
# Byte ALU with Flag Register

This block is the arithmetic and logic stage of a small 8-bit RISC core. It also holds the six arithmetic status flags: half carry (H), sign (S), overflow (V), negative (N), zero (Z) and carry (C). Each cycle with `op_valid` high, it applies the operation selected by `op_code` to one or two byte operands. The carry input is the flag register's own C bit. It registers the byte result and writes the new flag values. Each operation writes only the flags it is defined to affect, and all other flags keep their values.

The operations are:
- add and subtract, each with and without carry
- compare, and compare with carry
- AND, OR and XOR
- ones complement and twos-complement negate
- increment and decrement
- logical shifts left and right
- rotates left and right through carry
- arithmetic shift right
- nibble swap

S always equals N xor V. A signed greater-or-equal test can therefore read S directly. The chained forms (subtract with carry, compare with carry) treat Z as sticky. Multi-byte comparisons then give a correct zero result across all bytes.

The surrounding core decodes instructions, reads the register file onto `opa`/`opb`, and writes `res` back when `res_valid` is high. The interrupt-enable and bit-transfer flags are outside this block.

Top module: `byte_alu`

## Requirements
- R1: After reset, `res` is 0x00, `res_valid` is 0 and `status` is 0.
- R2: An operation accepted with `op_valid` high appears on `res`/`status` after the next rising edge, with `res_valid` high for exactly that one cycle. Opcodes: 0 add, 1 add+carry, 2 sub, 3 sub+carry, 4 compare, 5 compare+carry, 6 AND, 7 OR, 8 XOR, 9 complement, 10 negate, 11 increment, 12 decrement, 13 shift left, 14 shift right, 15 rotate left, 16 rotate right, 17 arithmetic shift right, 18 swap. `status` bits 5..0 are H,S,V,N,Z,C.
- R3: Add (carry-in 0) and add-with-carry (carry-in = C) produce the 8-bit sum and write all six flags: C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, N is bit 7 of the result and Z is set when the result is zero.
- R4: Subtract, compare (borrow-in 0) and negate (0 minus `opa`) write all six flags: C is the borrow out of bit 7, H is the borrow into bit 4, V is signed overflow. Compare forms return `opa` unchanged on `res`.
- R5: Subtract-with-carry and compare-with-carry (borrow-in = C) clear Z on a nonzero difference and leave Z unchanged on a zero difference.
- R6: AND, OR and XOR (of `opa` and `opb`) write Z and N, clear V, and leave C and H unchanged.
- R7: Increment and decrement of `opa` write Z and N. V is set only on 0x7F to 0x80 and on 0x80 to 0x7F. C and H are unchanged.
- R8: Complement returns 0xFF minus `opa`, sets C to 1, clears V, writes Z and N, and leaves H unchanged.
- R9: The shifts left and right fill with 0. Rotate left and rotate right fill with the old C. In all four, C takes the bit shifted out, V is N xor C, Z and N are written, and H is unchanged.
- R10: Arithmetic shift right keeps bit 7, moves bits 7..1 down one place, puts bit 0 into C, and sets flags as in R9.
- R11: Swap exchanges bits 7:4 with 3:0 and changes no flag.
- R12: S always equals N xor V.
- R13: With `op_valid` low, `status` and `res` hold and `res_valid` stays low. An accepted opcode above 18 returns `opa` on `res` and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accept the operation this cycle |
| op_code | input | 5 | Operation select (see R2) |
| opa | input | 8 | First operand / single-operand source |
| opb | input | 8 | Second operand |
| res | output | 8 | Registered result |
| res_valid | output | 1 | Result is fresh this cycle |
| status | output | 6 | Flags H,S,V,N,Z,C (bits 5..0) |

## Verification
The flag register has no load port, so every flag state the bench needs is built from earlier operations.

The sticky-zero rule is the hardest to reach. The bench must show that a zero difference keeps a cleared Z, and that it also keeps a set Z. It does this with a nonzero subtract followed by an equal-operand subtract-with-carry, and then an equal-operand subtract followed by the same chained form.

The rotates and the carry forms need C set first, which comes from an add that overflows 0xFF. A logic or increment operation placed right after a carry or half-carry event shows that C and H survive.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    // ordered to match status bits 5..0
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cy,
    output logic         hc,
    output logic         ovf
);
    localparam int HW = W / 2;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   wide;
    logic [HW:0]  low;

    // subtraction as a + ~b + ~borrow; carries invert into borrows
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low   = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
        sum   = wide[W-1:0];
        cy    = sub ? ~wide[W] : wide[W];
        hc    = sub ? ~low[HW] : low[HW];
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/byte_alu_bitops.sv
module byte_alu_bitops
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         sout
);
    localparam int HW = W / 2;

    always_comb begin
        r    = a;
        sout = 1'b0;
        unique case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_COM:  r = ~a;
            OP_LSL: begin
                r    = {a[W-2:0], 1'b0};
                sout = a[W-1];
            end
            OP_LSR: begin
                r    = {1'b0, a[W-1:1]};
                sout = a[0];
            end
            OP_ROL: begin
                r    = {a[W-2:0], cin};
                sout = a[W-1];
            end
            OP_ROR: begin
                r    = {cin, a[W-1:1]};
                sout = a[0];
            end
            OP_ASR: begin
                r    = {a[W-1], a[W-1:1]};
                sout = a[0];
            end
            OP_SWAP: r = {a[HW-1:0], a[W-1:HW]};
            default: begin
                r    = a;
                sout = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] op_code,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    output logic [W-1:0]     res,
    output logic             res_valid,
    output logic [5:0]       status
);
    localparam logic [W-1:0] ONE = W'(1);

    alu_op_e     op_w;
    alu_flags_t  flg_q, flg_d;
    logic [W-1:0] res_q, res_d;
    logic        vld_q;

    logic [W-1:0] as_a, as_b, as_sum;
    logic        as_cin, as_sub, as_cy, as_hc, as_ovf;
    logic [W-1:0] bo_r;
    logic        bo_sout;

    assign op_w = alu_op_e'(op_code);

    // operand steering for the shared adder
    always_comb begin
        as_a   = opa;
        as_b   = opb;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op_w)
            OP_ADC:         as_cin = flg_q.c;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                as_sub = 1'b1;
                as_cin = flg_q.c;
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = opa;
                as_sub = 1'b1;
            end
            OP_INC:         as_b = ONE;
            OP_DEC: begin
                as_b   = ONE;
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    byte_alu_addsub #(.W(W)) i_addsub (
        .a   (as_a),
        .b   (as_b),
        .cin (as_cin),
        .sub (as_sub),
        .sum (as_sum),
        .cy  (as_cy),
        .hc  (as_hc),
        .ovf (as_ovf)
    );

    byte_alu_bitops #(.W(W)) i_bitops (
        .op   (op_w),
        .a    (opa),
        .b    (opb),
        .cin  (flg_q.c),
        .r    (bo_r),
        .sout (bo_sout)
    );

    // next result and per-operation flag subset
    always_comb begin
        flg_d = flg_q;
        res_d = opa;
        unique case (op_w)
            OP_ADD, OP_ADC, OP_SUB, OP_NEG: begin
                res_d   = as_sum;
                flg_d.c = as_cy;
                flg_d.h = as_hc;
                flg_d.v = as_ovf;
                flg_d.n = as_sum[W-1];
                flg_d.z = (as_sum == '0);
            end
            OP_SBC: begin
                res_d   = as_sum;
                flg_d.c = as_cy;
                flg_d.h = as_hc;
                flg_d.v = as_ovf;
                flg_d.n = as_sum[W-1];
                flg_d.z = (as_sum == '0) & flg_q.z;
            end
            OP_CMP, OP_CPC: begin
                res_d   = opa;
                flg_d.c = as_cy;
                flg_d.h = as_hc;
                flg_d.v = as_ovf;
                flg_d.n = as_sum[W-1];
                flg_d.z = (op_w == OP_CPC) ? ((as_sum == '0) & flg_q.z)
                                           : (as_sum == '0);
            end
            OP_AND, OP_OR, OP_XOR, OP_COM: begin
                res_d   = bo_r;
                flg_d.v = 1'b0;
                flg_d.n = bo_r[W-1];
                flg_d.z = (bo_r == '0);
                if (op_w == OP_COM) flg_d.c = 1'b1;
            end
            OP_INC, OP_DEC: begin
                res_d   = as_sum;
                flg_d.v = as_ovf;
                flg_d.n = as_sum[W-1];
                flg_d.z = (as_sum == '0);
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                res_d   = bo_r;
                flg_d.c = bo_sout;
                flg_d.n = bo_r[W-1];
                flg_d.v = bo_r[W-1] ^ bo_sout;
                flg_d.z = (bo_r == '0);
            end
            OP_SWAP: res_d = bo_r;
            default: res_d = opa;
        endcase
        flg_d.s = flg_d.n ^ flg_d.v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= op_valid;
            if (op_valid) begin
                flg_q <= flg_d;
                res_q <= res_d;
            end
        end
    end

    assign res       = res_q;
    assign res_valid = vld_q;
    assign status    = flg_q;

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [4:0] op_code,
    input logic       res_valid,
    input logic [5:0] status
);
    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(status)));

    // R11
    swap_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd18) |=> $stable(status));

    // R12
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] == (status[3] ^ status[2]));

    // R6
    logic_clears_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 5'd6 || op_code == 5'd7 || op_code == 5'd8))
        |=> (!status[3] && status[5] == $past(status[5]) && status[0] == $past(status[0])));

    // R8
    com_sets_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd9) |=> (status[0] && !status[3]));

    // R7
    incdec_keeps_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 5'd11 || op_code == 5'd12))
        |=> (status[0] == $past(status[0]) && status[5] == $past(status[5])));

    // R9
    shift_v_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 5'd13 && op_code <= 5'd17)
        |=> (status[3] == (status[2] ^ status[0])));

endmodule

bind byte_alu byte_alu_chk i_byte_alu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .res_valid (res_valid),
    .status    (status)
);

// File: tb/test_byte_alu.sv
module test_byte_alu;
    localparam int C_ADD = 0,  C_ADC = 1,  C_SUB = 2,  C_SBC = 3,  C_CMP = 4;
    localparam int C_CPC = 5,  C_AND = 6,  C_OR  = 7,  C_XOR = 8,  C_COM = 9;
    localparam int C_NEG = 10, C_INC = 11, C_DEC = 12, C_LSL = 13, C_LSR = 14;
    localparam int C_ROL = 15, C_ROR = 16, C_ASR = 17, C_SWP = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opa = '0, opb = '0;
    logic [7:0] res;
    logic       res_valid;
    logic [5:0] status;

    int checks = 0;
    int errors = 0;
    logic [5:0] mflags = '0;

    typedef struct {
        logic [7:0] r;
        logic [5:0] f;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    byte_alu i_byte_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opa(opa), .opb(opb), .res(res), .res_valid(res_valid), .status(status)
    );

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // reference model written from the requirements; flags H,S,V,N,Z,C
    function automatic logic [13:0] ref_op(input int op, input int a, input int b,
                                           input logic [5:0] f);
        int r, d, cc;
        logic h, s, v, n, z, c, upd;
        h = f[5]; s = f[4]; v = f[3]; n = f[2]; z = f[1]; c = f[0];
        upd = 1'b1; r = a;
        case (op)
            C_ADD, C_ADC: begin
                cc = (op == C_ADC) ? int'(f[0]) : 0;
                d = a + b + cc; r = d % 256; c = (d > 255);
                h = ((a % 16) + (b % 16) + cc) > 15;
                d = sgn(a) + sgn(b) + cc; v = (d > 127) || (d < -128);
                z = (r == 0);
            end
            C_SUB, C_SBC, C_CMP, C_CPC: begin
                cc = (op == C_SBC || op == C_CPC) ? int'(f[0]) : 0;
                d = a - b - cc; r = (d + 256) % 256; c = (d < 0);
                h = (a % 16) < ((b % 16) + cc);
                d = sgn(a) - sgn(b) - cc; v = (d > 127) || (d < -128);
                if (op == C_SBC || op == C_CPC) z = (r == 0) && f[1];
                else z = (r == 0);
                n = (r >= 128);
                if (op == C_CMP || op == C_CPC) r = a;
            end
            C_NEG: begin
                r = (256 - a) % 256; c = (a != 0); h = (a % 16) != 0;
                v = (a == 128); z = (r == 0);
            end
            C_AND: begin r = a & b; v = 1'b0; z = (r == 0); end
            C_OR:  begin r = a | b; v = 1'b0; z = (r == 0); end
            C_XOR: begin r = a ^ b; v = 1'b0; z = (r == 0); end
            C_COM: begin r = 255 - a; c = 1'b1; v = 1'b0; z = (r == 0); end
            C_INC: begin r = (a + 1) % 256; v = (a == 127); z = (r == 0); end
            C_DEC: begin r = (a + 255) % 256; v = (a == 128); z = (r == 0); end
            C_LSL: begin r = (a * 2) % 256; c = (a >= 128); end
            C_LSR: begin r = a / 2; c = (a % 2) == 1; end
            C_ROL: begin r = (a * 2) % 256 + int'(f[0]); c = (a >= 128); end
            C_ROR: begin r = a / 2 + 128 * int'(f[0]); c = (a % 2) == 1; end
            C_ASR: begin r = a / 2 + (a & 128); c = (a % 2) == 1; end
            C_SWP: begin r = (a % 16) * 16 + a / 16; upd = 1'b0; end
            default: upd = 1'b0;
        endcase
        if (op >= C_LSL && op <= C_ASR) begin
            z = (r == 0);
            v = (r >= 128) ^ c;
        end
        if (upd) begin
            if (op != C_CMP && op != C_CPC) n = (r >= 128);
            s = n ^ v;
        end
        return {8'(r), h, s, v, n, z, c};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
        end
    endtask

    // driver: predicts, pushes to the scoreboard, then presents one operation
    task automatic drive(input int op, input int a, input int b, input string tag);
        logic [13:0] e;
        exp_t it;
        e = ref_op(op, a, b, mflags);
        it.r = e[13:6]; it.f = e[5:0]; it.tag = tag;
        sb.push_back(it);
        mflags = e[5:0];
        op_valid <= 1'b1;
        op_code  <= 5'(op);
        opa      <= 8'(a);
        opb      <= 8'(b);
        @(negedge clk);
        op_valid <= 1'b0;
    endtask

    // monitor: pops one expected item per result
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected res_valid", 1, 0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                check(res == it.r, {it.tag, " res"}, res, it.r);
                check(status == it.f, {it.tag, " status"}, status, it.f);
                // R12
                check(status[4] == (status[3] ^ status[2]), "R12 S=N^V", status, it.f);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(res == 8'h00, "R1 res", res, 0);
        check(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        check(status == 6'h00, "R1 status", status, 0);
        rst_n = 1'b1;
        @(negedge clk);

        drive(C_ADD, 8'h0F, 8'h01, "R3 half carry");
        drive(C_ADD, 8'h7F, 8'h01, "R3 overflow");
        drive(C_ADD, 8'hFF, 8'h01, "R3 carry zero");
        drive(C_ADC, 8'h10, 8'h20, "R3 adc with C");
        drive(C_SUB, 8'h10, 8'h01, "R4 half borrow");
        drive(C_SUB, 8'h00, 8'h01, "R4 borrow");
        drive(C_SUB, 8'h80, 8'h01, "R4 overflow");
        drive(C_CMP, 8'h33, 8'h44, "R4 compare keeps opa");
        drive(C_NEG, 8'h01, 8'h00, "R4 negate 1");
        drive(C_NEG, 8'h80, 8'h00, "R4 negate 0x80");
        drive(C_NEG, 8'h00, 8'h00, "R4 negate 0");
        drive(C_SUB, 8'h05, 8'h03, "R4 nonzero sub");
        drive(C_SBC, 8'h03, 8'h03, "R5 zero keeps Z clear");
        drive(C_SUB, 8'h03, 8'h03, "R4 zero sub");
        drive(C_SBC, 8'h03, 8'h03, "R5 zero keeps Z set");
        drive(C_CPC, 8'h07, 8'h03, "R5 cpc nonzero clears Z");
        drive(C_SUB, 8'h00, 8'h01, "R4 set C and H");
        drive(C_AND, 8'hF0, 8'h3C, "R6 and keeps C H");
        drive(C_OR,  8'h80, 8'h01, "R6 or");
        drive(C_XOR, 8'h5A, 8'h5A, "R6 xor zero");
        drive(C_INC, 8'h7F, 8'h00, "R7 inc overflow");
        drive(C_DEC, 8'h80, 8'h00, "R7 dec overflow");
        drive(C_INC, 8'hFF, 8'h00, "R7 inc wrap keeps C");
        drive(C_COM, 8'h55, 8'h00, "R8 complement");
        drive(C_COM, 8'hFF, 8'h00, "R8 complement zero");
        drive(C_LSL, 8'h81, 8'h00, "R9 shift left");
        drive(C_ROL, 8'h40, 8'h00, "R9 rotate left old C");
        drive(C_LSR, 8'h01, 8'h00, "R9 shift right");
        drive(C_ROR, 8'h02, 8'h00, "R9 rotate right old C");
        drive(C_ASR, 8'h81, 8'h00, "R10 asr negative");
        drive(C_ASR, 8'h40, 8'h00, "R10 asr positive");
        drive(C_SWP, 8'hA5, 8'h00, "R11 swap");
        drive(5'd25, 8'h3C, 8'h11, "R13 unused code");

        // R13: idle cycles with operands present touch nothing
        op_code <= 5'(C_ADD); opa <= 8'hFF; opb <= 8'hFF;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(res_valid == 1'b0, "R13 idle res_valid", res_valid, 0);
        check(status == mflags, "R13 idle status", status, mflags);
        check(res == 8'h3C, "R13 idle res", res, 8'h3C);
        check(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule